// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the command logic of a byte-wide parallel NOR flash. A host drives chip enable, write enable and output enable low-active strobes. The block samples them on its own clock, along with a 17-bit address and an 8-bit write data bus. Writes are decoded as unlock-and-command sequences. These start self-timed byte programs or sector erases against an internal byte array. While an operation runs, reads return a polling status byte instead of array contents.

An erase can be suspended. During the suspension, other sectors can be read and programmed, and a resume command continues the erase. A faster program path lets the host skip the unlock writes. A per-sector lock input, a low-supply write inhibit and an active-low reset complete the block. The stored array covers the low `ARR_AW` address bits, and higher address bits alias onto it. Unlock and command address matching uses address bits 10..0.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: When no operation is running and the chip is selected with output enable low, `dout` shows the stored byte at the address. Every byte initially reads 0xFF. With chip enable or output enable high, `dout` is 0xFF.
- R2: A write is taken when write enable rises while chip enable is low. A byte program is started by four writes: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, and then the data byte at the target address.
- R3: A program never sets a bit. The stored result is the old byte AND the written data, and it is stored `PROG_CYC` cycles after the operation starts.
- R4: While an operation is running, a read returns a status byte. Bit 7 is the complement of bit 7 of the program data during a program, and 0 during an erase. Bit 6 inverts after each completed read (output enable rising). Bits 5..0 are 0.
- R5: When an operation finishes, reads return array data again and a new command sequence is accepted. Writes made while an operation runs start no new operation.
- R6: A sector erase is started by six writes: 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, and then 0x30 at any address inside the sector. The erase first writes 0x00 to every byte of the sector, then waits `ERS_CYC` cycles, then writes 0xFF to every byte. Other sectors are unchanged.
- R7: Bypass mode is entered with the two unlock writes followed by 0x20 at 0x555. In this mode, 0xA0 followed by a data write programs a byte, and the block stays in bypass mode. The write pair 0x90 then 0x00 leaves bypass mode. After that, an 0xA0 and data pair alone programs nothing.
- R8: A write that does not fit the expected sequence drops the partial sequence and returns to read mode. Nothing is programmed.
- R9: Writing 0xB0 during an erase suspends it. While it is suspended, other sectors read as array data and accept the four-write program. Reads inside the erasing sector return erase status. A later write of 0x30 continues the erase to completion.
- R10: A program or erase aimed at a sector whose `sec_lock` bit is set does not start and does not change the array.
- R11: While `vcc_low` is high, every write is ignored.
- R12: Asserting `rst_n` low aborts any running or suspended operation and returns the block to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status |
| vcc_low | input | 1 | Low-supply indication; blocks all writes |
| sec_lock | input | NSEC | Per-sector protection flags |

## Verification
The bench builds the block with `ARR_AW`=8 and `NSEC`=4, which gives four 64-byte sectors, and with `PROG_CYC`=8 and `ERS_CYC`=12. A full sector erase therefore takes about 140 cycles. This lets the bench run several complete erases, a suspend in the middle of the preprogram phase, and a reset in the middle of an erase. The program length of 8 cycles leaves room for two status reads before a program ends. The bench can therefore check both the Data# bit and the DQ6 inversion on a real program.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam int BUS_AW = 17;

    localparam logic [10:0] UNLK_A1 = 11'h555;
    localparam logic [10:0] UNLK_A2 = 11'h2AA;

    localparam logic [7:0] CD_UNLK1     = 8'hAA;
    localparam logic [7:0] CD_UNLK2     = 8'h55;
    localparam logic [7:0] CD_PGM       = 8'hA0;
    localparam logic [7:0] CD_ESETUP    = 8'h80;
    localparam logic [7:0] CD_SERASE    = 8'h30;
    localparam logic [7:0] CD_SUSP      = 8'hB0;
    localparam logic [7:0] CD_RESUME    = 8'h30;
    localparam logic [7:0] CD_BYP_ENTER = 8'h20;
    localparam logic [7:0] CD_BYP_EXIT1 = 8'h90;

    typedef enum logic [3:0] {
        C_READ, C_UNL1, C_UNL2, C_PDATA,
        C_ESET, C_EUNL1, C_EUNL2,
        C_BYP, C_BPDATA, C_BEXIT
    } dec_st_e;

    typedef enum logic [2:0] {
        Q_IDLE, Q_PGM, Q_PRE, Q_WAIT, Q_FILL, Q_SUSP
    } seq_st_e;

endpackage

// File: rtl/nor_bus_strobe.sv
module nor_bus_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic vcc_low,
    output logic wr_stb,
    output logic rd_end,
    output logic rd_act
);
    typedef struct packed {
        logic we_hi;
        logic oe_hi;
    } strb_t;

    strb_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.we_hi = we_n;
        s_d.oe_hi = oe_n;
        wr_stb    = !ce_n && we_n && !s_q.we_hi && !vcc_low;
        rd_end    = !ce_n && oe_n && !s_q.oe_hi;
        rd_act    = !ce_n && !oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{we_hi: 1'b1, oe_hi: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    AST_ONE_WRITE_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R2

endmodule

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
    import nor_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  logic [10:0] ua,
    input  logic [7:0]  wd,
    input  logic        seq_run,
    input  logic        seq_ers,
    input  logic        seq_susp,
    output logic        cmd_pgm,
    output logic        cmd_ers,
    output logic        cmd_susp,
    output logic        cmd_res
);
    typedef struct packed {
        dec_st_e st;
    } dec_t;

    dec_t s_d, s_q;

    logic is_unl1, is_unl2;

    always_comb begin
        is_unl1  = (wd == CD_UNLK1) && (ua == UNLK_A1);
        is_unl2  = (wd == CD_UNLK2) && (ua == UNLK_A2);
        s_d      = s_q;
        cmd_pgm  = 1'b0;
        cmd_ers  = 1'b0;
        cmd_susp = 1'b0;
        cmd_res  = 1'b0;
        if (wr_stb) begin
            if (seq_run) begin
                if (seq_ers && (wd == CD_SUSP)) cmd_susp = 1'b1;
            end else begin
                unique case (s_q.st)
                    C_READ: begin
                        if (is_unl1) begin
                            s_d.st = C_UNL1;
                        end else begin
                            s_d.st = C_READ;
                            if (seq_susp && (wd == CD_RESUME)) cmd_res = 1'b1;
                        end
                    end
                    C_UNL1: s_d.st = is_unl2 ? C_UNL2 : C_READ;
                    C_UNL2: begin
                        s_d.st = C_READ;
                        if (ua == UNLK_A1) begin
                            if (wd == CD_PGM) s_d.st = C_PDATA;
                            else if (wd == CD_ESETUP && !seq_susp) s_d.st = C_ESET;
                            else if (wd == CD_BYP_ENTER && !seq_susp) s_d.st = C_BYP;
                        end
                    end
                    C_PDATA: begin
                        cmd_pgm = 1'b1;
                        s_d.st  = C_READ;
                    end
                    C_ESET:  s_d.st = is_unl1 ? C_EUNL1 : C_READ;
                    C_EUNL1: s_d.st = is_unl2 ? C_EUNL2 : C_READ;
                    C_EUNL2: begin
                        if (wd == CD_SERASE) cmd_ers = 1'b1;
                        s_d.st = C_READ;
                    end
                    C_BYP: begin
                        if (wd == CD_PGM) s_d.st = C_BPDATA;
                        else if (wd == CD_BYP_EXIT1) s_d.st = C_BEXIT;
                        else s_d.st = C_READ;
                    end
                    C_BPDATA: begin
                        cmd_pgm = 1'b1;
                        s_d.st  = C_BYP;
                    end
                    C_BEXIT: s_d.st = C_READ;
                    default: s_d.st = C_READ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: C_READ};
        end else begin
            s_q <= s_d;
        end
    end

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_run |-> !(cmd_pgm || cmd_ers || cmd_res)); // R5

    AST_RESUME_NEEDS_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_res |-> seq_susp); // R9

    AST_SUSP_ONLY_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_susp |-> seq_ers); // R9

endmodule

// File: rtl/nor_embed_seq.sv
module nor_embed_seq
    import nor_cmd_pkg::*;
#(
    parameter int ARR_AW   = 10,
    parameter int NSEC     = 4,
    parameter int PROG_CYC = 16,
    parameter int ERS_CYC  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARR_AW-1:0] addr,
    input  logic [7:0]        din,
    input  logic [NSEC-1:0]   sec_lock,
    input  logic              rd_end,
    input  logic              cmd_pgm,
    input  logic              cmd_ers,
    input  logic              cmd_susp,
    input  logic              cmd_res,
    output logic              run,
    output logic              ers_run,
    output logic              susp,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ARR_AW;
    localparam int SEC_W = (NSEC > 1) ? $clog2(NSEC) : 1;
    localparam int OFF_W = ARR_AW - SEC_W;
    localparam int PC_W  = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;
    localparam int EC_W  = (ERS_CYC > 1) ? $clog2(ERS_CYC) : 1;

    typedef struct packed {
        seq_st_e           st;
        seq_st_e           sv_st;
        logic              ret_susp;
        logic [ARR_AW-1:0] pa;
        logic [7:0]        pd;
        logic [PC_W-1:0]   pcnt;
        logic [EC_W-1:0]   ecnt;
        logic [SEC_W-1:0]  esec;
        logic [OFF_W-1:0]  ptr;
        logic              tog;
    } seq_t;

    seq_t s_d, s_q;

    logic [7:0]        mem [DEPTH];
    logic              mem_we;
    logic [ARR_AW-1:0] mem_wa;
    logic [7:0]        mem_wd;
    logic [SEC_W-1:0]  a_sec;
    logic              stat_sel;
    logic              last_ptr;

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
    end

    always_comb begin
        a_sec    = addr[ARR_AW-1 -: SEC_W];
        last_ptr = (s_q.ptr == {OFF_W{1'b1}});
        run      = (s_q.st != Q_IDLE) && (s_q.st != Q_SUSP);
        ers_run  = (s_q.st == Q_PRE) || (s_q.st == Q_WAIT) || (s_q.st == Q_FILL);
        susp     = (s_q.st == Q_SUSP);
        stat_sel = run || (susp && (a_sec == s_q.esec));

        s_d    = s_q;
        mem_we = 1'b0;
        mem_wa = s_q.pa;
        mem_wd = 8'h00;

        unique case (s_q.st)
            Q_IDLE: begin
                if (cmd_pgm && !sec_lock[a_sec]) begin
                    s_d.st       = Q_PGM;
                    s_d.ret_susp = 1'b0;
                    s_d.pa       = addr;
                    s_d.pd       = din;
                    s_d.pcnt     = PC_W'(PROG_CYC - 1);
                end else if (cmd_ers && !sec_lock[a_sec]) begin
                    s_d.st   = Q_PRE;
                    s_d.esec = a_sec;
                    s_d.ptr  = '0;
                end
            end
            Q_PGM: begin
                if (s_q.pcnt == '0) begin
                    mem_we = 1'b1;
                    mem_wa = s_q.pa;
                    mem_wd = mem[s_q.pa] & s_q.pd;
                    s_d.st = s_q.ret_susp ? Q_SUSP : Q_IDLE;
                end else begin
                    s_d.pcnt = s_q.pcnt - 1'b1;
                end
            end
            Q_PRE, Q_WAIT, Q_FILL: begin
                if (cmd_susp) begin
                    s_d.sv_st = s_q.st;
                    s_d.st    = Q_SUSP;
                end else if (s_q.st == Q_PRE) begin
                    mem_we = 1'b1;
                    mem_wa = {s_q.esec, s_q.ptr};
                    mem_wd = 8'h00;
                    if (last_ptr) begin
                        s_d.st   = Q_WAIT;
                        s_d.ptr  = '0;
                        s_d.ecnt = EC_W'(ERS_CYC - 1);
                    end else begin
                        s_d.ptr = s_q.ptr + 1'b1;
                    end
                end else if (s_q.st == Q_WAIT) begin
                    if (s_q.ecnt == '0) begin
                        s_d.st  = Q_FILL;
                        s_d.ptr = '0;
                    end else begin
                        s_d.ecnt = s_q.ecnt - 1'b1;
                    end
                end else begin
                    mem_we = 1'b1;
                    mem_wa = {s_q.esec, s_q.ptr};
                    mem_wd = 8'hFF;
                    if (last_ptr) s_d.st = Q_IDLE;
                    else s_d.ptr = s_q.ptr + 1'b1;
                end
            end
            Q_SUSP: begin
                if (cmd_res) begin
                    s_d.st = s_q.sv_st;
                end else if (cmd_pgm && !sec_lock[a_sec] && (a_sec != s_q.esec)) begin
                    s_d.st       = Q_PGM;
                    s_d.ret_susp = 1'b1;
                    s_d.pa       = addr;
                    s_d.pd       = din;
                    s_d.pcnt     = PC_W'(PROG_CYC - 1);
                end
            end
            default: s_d.st = Q_IDLE;
        endcase

        if (rd_end && stat_sel) s_d.tog = ~s_q.tog;

        if (stat_sel) begin
            rd_data = {(s_q.st == Q_PGM) ? ~s_q.pd[7] : 1'b0, s_q.tog, 6'b000000};
        end else begin
            rd_data = mem[addr];
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_wa] <= mem_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: Q_IDLE, sv_st: Q_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    AST_LOCKED_PGM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == Q_IDLE && cmd_pgm && sec_lock[a_sec]) |=> (s_q.st == Q_IDLE)); // R10

    AST_SUSP_HOLDS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == Q_SUSP) |-> (s_q.sv_st inside {Q_PRE, Q_WAIT, Q_FILL})); // R9

    AST_STATUS_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && run) |=> (s_q.tog != $past(s_q.tog))); // R4

    AST_FILL_RETURNS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == Q_FILL && !cmd_susp && last_ptr) |=> (s_q.st == Q_IDLE)); // R6

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
    import nor_cmd_pkg::*;
#(
    parameter int ARR_AW   = 10,
    parameter int NSEC     = 4,
    parameter int PROG_CYC = 16,
    parameter int ERS_CYC  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    input  logic              vcc_low,
    input  logic [NSEC-1:0]   sec_lock
);
    localparam int USED_W = (ARR_AW > 11) ? ARR_AW : 11;

    logic wr_stb, rd_end, rd_act;
    logic cmd_pgm, cmd_ers, cmd_susp, cmd_res;
    logic run, ers_run, susp;
    logic [7:0] rd_data;
    logic hi_addr_unused;

    assign hi_addr_unused = ^addr[BUS_AW-1:USED_W];

    nor_bus_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .vcc_low (vcc_low),
        .wr_stb  (wr_stb),
        .rd_end  (rd_end),
        .rd_act  (rd_act)
    );

    nor_cmd_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .ua       (addr[10:0]),
        .wd       (din),
        .seq_run  (run),
        .seq_ers  (ers_run),
        .seq_susp (susp),
        .cmd_pgm  (cmd_pgm),
        .cmd_ers  (cmd_ers),
        .cmd_susp (cmd_susp),
        .cmd_res  (cmd_res)
    );

    nor_embed_seq #(
        .ARR_AW   (ARR_AW),
        .NSEC     (NSEC),
        .PROG_CYC (PROG_CYC),
        .ERS_CYC  (ERS_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr[ARR_AW-1:0]),
        .din      (din),
        .sec_lock (sec_lock),
        .rd_end   (rd_end),
        .cmd_pgm  (cmd_pgm),
        .cmd_ers  (cmd_ers),
        .cmd_susp (cmd_susp),
        .cmd_res  (cmd_res),
        .run      (run),
        .ers_run  (ers_run),
        .susp     (susp),
        .rd_data  (rd_data)
    );

    assign dout = rd_act ? rd_data : 8'hFF;

    AST_ERASE_DQ7_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && ers_run) |-> (dout[7] == 1'b0)); // R4

    AST_LOWV_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_low && !run) |=> !run); // R11

    AST_DESELECT_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |-> (dout == 8'hFF)); // R1

endmodule

// File: tb/nor_cmd_ctrl_bench.sv
module nor_cmd_ctrl_bench;
    localparam int ARR_AW = 8;
    localparam int NSEC   = 4;
    localparam int PCYC   = 8;
    localparam int ECYC   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vcc_low = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic [NSEC-1:0] sec_lock = '0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];
    string      tag_q[$];
    event       got_ev;

    always #10 clk = ~clk;

    nor_cmd_ctrl #(.ARR_AW(ARR_AW), .NSEC(NSEC), .PROG_CYC(PCYC), .ERS_CYC(ECYC)) u_nor_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .vcc_low(vcc_low), .sec_lock(sec_lock)
    );

    initial begin
        forever begin
            @(got_ev);
            while (act_q.size() > 0) begin
                logic [7:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s actual=%02h expected=%02h", t, a, e);
                end
            end
        end
    end

    task automatic note(input logic [7:0] act, input logic [7:0] exp, input string tag);
        act_q.push_back(act);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        -> got_ev;
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [16:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; oe_n = 1'b0;
        @(negedge clk); d = dout; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic expect_rd(input logic [16:0] a, input logic [7:0] e, input string tag);
        logic [7:0] d;
        rd(a, d);
        note(d, e, tag);
    endtask

    task automatic poll(input logic [16:0] a, input string tag);
        logic [7:0] d1, d2;
        bit ok = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(a, d1);
            rd(a, d2);
            if (d1[6] == d2[6]) begin ok = 1; break; end
        end
        if (!ok) note(8'h00, 8'h01, tag);
    endtask

    task automatic unlock();
        wr(17'h555, 8'hAA);
        wr(17'h2AA, 8'h55);
    endtask

    task automatic pgm4(input logic [16:0] a, input logic [7:0] d);
        unlock();
        wr(17'h555, 8'hA0);
        wr(a, d);
    endtask

    task automatic erase(input logic [16:0] a);
        unlock();
        wr(17'h555, 8'h80);
        unlock();
        wr(a, 8'h30);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] s1, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ce_n = 1'b0;

        // R1: erased array and idle bus
        expect_rd(17'h000, 8'hFF, "R1 reset read 0x000");
        expect_rd(17'h0FF, 8'hFF, "R1 reset read 0x0FF");
        @(negedge clk); ce_n = 1'b1; addr = 17'h0; oe_n = 1'b0;
        @(negedge clk); note(dout, 8'hFF, "R1 deselected bus");
        oe_n = 1'b1; ce_n = 1'b0;
        @(negedge clk);

        // R2 R3 R4: four-write program with status
        pgm4(17'h005, 8'h3C);
        rd(17'h005, s1);
        rd(17'h005, s2);
        note({7'd0, s1[7]}, 8'h01, "R4 program DQ7 is complement");
        note({7'd0, s1[6] ^ s2[6]}, 8'h01, "R4 DQ6 inverts per read");
        note(s1 & 8'h3F, 8'h00, "R4 low status bits zero");
        poll(17'h005, "R5 program completes");
        expect_rd(17'h005, 8'h3C, "R2 programmed byte");
        pgm4(17'h005, 8'hF0);
        poll(17'h005, "R5 second program completes");
        expect_rd(17'h005, 8'h30, "R3 program ANDs");
        pgm4(17'h045, 8'h55);
        poll(17'h045, "R5 program sector1");

        // R7: bypass
        unlock();
        wr(17'h555, 8'h20);
        wr(17'h000, 8'hA0);
        wr(17'h010, 8'h12);
        poll(17'h010, "R7 bypass program 1");
        wr(17'h000, 8'hA0);
        wr(17'h011, 8'h34);
        poll(17'h011, "R7 bypass program 2");
        expect_rd(17'h010, 8'h12, "R7 bypass byte 0x010");
        expect_rd(17'h011, 8'h34, "R7 bypass byte 0x011");
        wr(17'h000, 8'h90);
        wr(17'h000, 8'h00);
        wr(17'h000, 8'hA0);
        wr(17'h012, 8'h00);
        expect_rd(17'h012, 8'hFF, "R7 after exit pair ignored");

        // R8: broken sequence
        wr(17'h555, 8'hAA);
        wr(17'h2AA, 8'h12);
        wr(17'h555, 8'hA0);
        wr(17'h020, 8'h00);
        expect_rd(17'h020, 8'hFF, "R8 out of sequence no program");

        // R6: sector erase
        erase(17'h000);
        rd(17'h003, s1);
        note({7'd0, s1[7]}, 8'h00, "R4 erase DQ7 low");
        poll(17'h000, "R6 erase completes");
        expect_rd(17'h005, 8'hFF, "R6 erased 0x005");
        expect_rd(17'h010, 8'hFF, "R6 erased 0x010");
        expect_rd(17'h045, 8'h55, "R6 other sector kept");

        // R9: suspend and resume
        pgm4(17'h007, 8'h11);
        poll(17'h007, "R9 setup program");
        expect_rd(17'h007, 8'h11, "R9 setup byte");
        erase(17'h000);
        wr(17'h000, 8'hB0);
        expect_rd(17'h045, 8'h55, "R9 read other sector while suspended");
        rd(17'h007, s1);
        rd(17'h007, s2);
        note({7'd0, s1[6] ^ s2[6]}, 8'h01, "R9 erasing sector shows status");
        pgm4(17'h046, 8'h66);
        poll(17'h046, "R9 program during suspend");
        expect_rd(17'h046, 8'h66, "R9 byte programmed while suspended");
        wr(17'h000, 8'h30);
        poll(17'h000, "R9 resumed erase completes");
        expect_rd(17'h007, 8'hFF, "R9 erase finished after resume");

        // R10: lock
        sec_lock = 4'b1000;
        pgm4(17'h0C1, 8'h00);
        expect_rd(17'h0C1, 8'hFF, "R10 locked byte unchanged");
        expect_rd(17'h0C1, 8'hFF, "R10 no status after locked program");
        pgm4(17'h081, 8'h0F);
        poll(17'h081, "R10 unlocked sector program");
        expect_rd(17'h081, 8'h0F, "R10 unlocked sector writable");

        // R11: low supply
        vcc_low = 1'b1;
        pgm4(17'h047, 8'h00);
        vcc_low = 1'b0;
        expect_rd(17'h047, 8'hFF, "R11 write inhibited");
        expect_rd(17'h047, 8'hFF, "R11 no operation started");

        // R12: reset abort
        erase(17'h040);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        expect_rd(17'h080, 8'hFF, "R12 array read after reset");
        expect_rd(17'h080, 8'hFF, "R12 no status after reset");
        pgm4(17'h080, 8'h5A);
        poll(17'h080, "R12 program after reset");
        expect_rd(17'h080, 8'h5A, "R12 new command accepted");

        #1;
        -> got_ev;
        #1;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule